// File: doc/BRIEF.md
# Per-Thread Instruction Serialization Gate

This block sits at the register-dependence stage of a multithreaded in-order pipeline. It sees one instruction request per cycle and decides in the same cycle whether that request may proceed or must stall. It enforces three ordering rules for each hardware thread. First, an instruction that must run alone in the pipeline waits until it is the oldest in-flight instruction of its thread. Second, an instruction that must be followed by an empty pipeline arms a flag that forces this treatment on the next younger instruction of the same thread. Third, instructions that are younger than an active non-speculative instruction are held back.

Each thread has a small state machine with two states. `ARM_IDLE` means no serialization is pending. `ARM_WAIT` means a serialize-after instruction has been granted and its sequence number is held. The named transitions are:

- *arm*: `ARM_IDLE`→`ARM_WAIT`, or *re-arm*: `ARM_WAIT`→`ARM_WAIT`, when a store-conditional or serialize-after request is granted.
- *consume*: `ARM_WAIT`→`ARM_IDLE`, when the younger instruction that the flag marked is finally granted.
- *flush*: any state→`ARM_IDLE`.
- *hold*: no change otherwise.

A separate slot limiter on the execute side grants at most one control-flow instruction per cycle among several lanes.

Top module: `serial_gate`

## Requirements
- R1: After reset every thread is unarmed. A request with no class flags and no non-speculative hazard is granted with `req_serialized` low.
- R2: When the request's thread is armed and `req_seq` is strictly greater than the held number, the request is marked: `req_serialized` is high and the request is handled as serialize-before. A request with `req_seq` equal to or below the held number is not marked.
- R3: A request flagged serialize-before, flagged as a processor register access, or marked under R2 stalls unless `req_seq` equals `req_oldest_seq`.
- R4: A store-conditional or serialize-after request does not stall on its own account. When it is granted, its thread is armed from the next cycle and `req_seq` is held.
- R5: While `ns_active[t]` is high, a request of thread t whose `req_seq` exceeds `ns_seq` of thread t (bits `t*SEQ_W +: SEQ_W`) stalls.
- R6: A request with `req_fault` high is always granted and has `req_serialized` low. It leaves all thread state unchanged.
- R7: Of the `ex_ctrl_req` lanes, only the lowest-numbered requesting lane is granted in a cycle. Every other lane is refused.
- R8: An armed flag survives any number of stalled cycles of its marked request. It clears only in the cycle after the marked request is granted.
- R9: `thread_flush[t]` clears thread t's flag on the next edge. It takes priority over arming in the same cycle.
- R10: The state of each thread affects only requests carrying that thread's `req_tid`.
- R11: `req_stall` equals `req_valid` and not `req_grant`. With `req_valid` low, grant, stall and serialized are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_tid | input | TID_W | Thread of the request |
| req_seq | input | SEQ_W | Sequence number of the request |
| req_fault | input | 1 | Request already carries a fault |
| req_ser_before | input | 1 | Request must be oldest to proceed |
| req_ser_after | input | 1 | Request serializes its successor |
| req_reg_access | input | 1 | Processor register access, handled as serialize-before |
| req_store_cond | input | 1 | Store-conditional, handled as serialize-after |
| req_oldest_seq | input | SEQ_W | Oldest in-flight sequence number of the request's thread |
| ns_active | input | NT | Per thread: a non-speculative instruction is active |
| ns_seq | input | NT*SEQ_W | Per thread: sequence number of that instruction |
| thread_flush | input | NT | Per thread: clear the pending serialization |
| ex_ctrl_req | input | LANES | Execute lanes holding a control-flow instruction |
| req_grant | output | 1 | Request proceeds this cycle |
| req_stall | output | 1 | Request must be re-presented |
| req_serialized | output | 1 | Request was marked serialize-before by a pending flag |
| ex_ctrl_grant | output | LANES | Lane allowed to execute its control-flow instruction |

## Verification
Grant, stall, serialized and the control-lane grants are all combinational, so they are due in the same cycle as the request. The bench drives inputs on the falling edge and samples them one nanosecond later. A state change from arming, consuming or flushing shows up only on a request presented after the next rising edge. The bench's reference model therefore updates its per-thread flags at that edge and predicts the next request from them. Sweeps over every combination of class flags, fault, oldest match and non-speculative hazard let the armed state wander across both threads. Directed sequences cover persistence across stalls and flush priority.

// File: rtl/sg_pkg.sv
package sg_pkg;

    // Per-thread serialization state
    typedef enum logic {
        ARM_IDLE = 1'b0,   // nothing pending
        ARM_WAIT = 1'b1    // next younger instruction must serialize
    } arm_state_t;

    // Class flags of one request
    typedef struct packed {
        logic ser_before;
        logic ser_after;
        logic reg_access;
        logic store_cond;
    } ins_class_t;

endpackage

// File: rtl/sg_thread_fsm.sv
module sg_thread_fsm
    import sg_pkg::*;
#(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             arm,
    input  logic             consume,
    input  logic [SEQ_W-1:0] arm_seq,
    output logic             armed,
    output logic [SEQ_W-1:0] saved_seq
);

    arm_state_t state_q;
    arm_state_t state_d;

    // Next-state logic: flush wins, then arm/re-arm, then consume
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE: begin
                if (flush)
                    state_d = ARM_IDLE;
                else if (arm)
                    state_d = ARM_WAIT;
            end
            ARM_WAIT: begin
                if (flush)
                    state_d = ARM_IDLE;
                else if (arm)
                    state_d = ARM_WAIT;
                else if (consume)
                    state_d = ARM_IDLE;
            end
            default: state_d = ARM_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ARM_IDLE;
        else
            state_q <= state_d;
    end

    // Held sequence number of the arming instruction
    always_ff @(posedge clk) begin
        if (!rst_n)
            saved_seq <= '0;
        else if (arm && !flush)
            saved_seq <= arm_seq;
    end

    // Outputs
    always_comb begin
        armed = (state_q == ARM_WAIT);
    end

    p_arm_holds_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !flush) |=> (state_q == ARM_WAIT && saved_seq == $past(arm_seq)));

    p_flag_persists_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARM_WAIT && !consume && !flush) |=> (state_q == ARM_WAIT));

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state_q == ARM_IDLE));

endmodule

// File: rtl/sg_decide.sv
module sg_decide
    import sg_pkg::*;
#(
    parameter int SEQ_W = 16
) (
    input  logic             valid,
    input  logic             fault,
    input  ins_class_t       cls,
    input  logic [SEQ_W-1:0] seq,
    input  logic [SEQ_W-1:0] oldest_seq,
    input  logic             armed,
    input  logic [SEQ_W-1:0] saved_seq,
    input  logic             ns_active,
    input  logic [SEQ_W-1:0] ns_seq,
    output logic             grant,
    output logic             stall,
    output logic             marked,
    output logic             arm,
    output logic             consume
);

    logic hit_mark;
    logic must_be_oldest;
    logic stall_order;
    logic stall_nonspec;
    logic arms_next;

    always_comb begin
        // a pending flag turns a strictly younger request into serialize-before
        hit_mark       = armed && (seq > saved_seq);
        must_be_oldest = cls.ser_before || cls.reg_access || hit_mark;
        stall_order    = must_be_oldest && (seq != oldest_seq);
        stall_nonspec  = ns_active && (seq > ns_seq);
        arms_next      = cls.store_cond || cls.ser_after;

        if (!valid) begin
            grant = 1'b0;
        end else if (fault) begin
            grant = 1'b1;            // faulted requests skip every rule
        end else begin
            grant = !(stall_order || stall_nonspec);
        end

        stall   = valid && !grant;
        marked  = valid && !fault && hit_mark;
        arm     = grant && !fault && arms_next;
        consume = grant && !fault && hit_mark;
    end

endmodule

// File: rtl/sg_ctrl_limiter.sv
module sg_ctrl_limiter #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] ctrl_req,
    output logic [LANES-1:0] ctrl_grant
);

    // taken[i] is high when some lane below i already requested
    logic [LANES:0] taken;

    assign taken[0] = 1'b0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign taken[i+1]    = taken[i] || ctrl_req[i];
        assign ctrl_grant[i] = ctrl_req[i] && !taken[i];
    end

    p_one_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctrl_grant));

    p_lane0_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_req[0] |-> ctrl_grant[0]);

    p_grant_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_req == '0) |-> (ctrl_grant == '0));

endmodule

// File: rtl/serial_gate.sv
module serial_gate
    import sg_pkg::*;
#(
    parameter int NT    = 2,
    parameter int SEQ_W = 16,
    parameter int LANES = 2,
    localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [TID_W-1:0]    req_tid,
    input  logic [SEQ_W-1:0]    req_seq,
    input  logic                req_fault,
    input  logic                req_ser_before,
    input  logic                req_ser_after,
    input  logic                req_reg_access,
    input  logic                req_store_cond,
    input  logic [SEQ_W-1:0]    req_oldest_seq,
    input  logic [NT-1:0]       ns_active,
    input  logic [NT*SEQ_W-1:0] ns_seq,
    input  logic [NT-1:0]       thread_flush,
    input  logic [LANES-1:0]    ex_ctrl_req,
    output logic                req_grant,
    output logic                req_stall,
    output logic                req_serialized,
    output logic [LANES-1:0]    ex_ctrl_grant
);

    logic [NT-1:0]            armed_vec;
    logic [NT*SEQ_W-1:0]      saved_vec;
    logic [NT-1:0]            arm_vec;
    logic [NT-1:0]            consume_vec;

    logic                     sel_armed;
    logic [SEQ_W-1:0]         sel_saved;
    logic                     sel_ns_active;
    logic [SEQ_W-1:0]         sel_ns_seq;
    logic                     dec_arm;
    logic                     dec_consume;
    ins_class_t               req_cls;

    assign req_cls = '{ser_before: req_ser_before,
                       ser_after:  req_ser_after,
                       reg_access: req_reg_access,
                       store_cond: req_store_cond};

    // Pick the state of the requesting thread
    always_comb begin
        sel_armed     = 1'b0;
        sel_saved     = '0;
        sel_ns_active = 1'b0;
        sel_ns_seq    = '0;
        for (int t = 0; t < NT; t++) begin
            if (req_tid == TID_W'(t)) begin
                sel_armed     = armed_vec[t];
                sel_saved     = saved_vec[t*SEQ_W +: SEQ_W];
                sel_ns_active = ns_active[t];
                sel_ns_seq    = ns_seq[t*SEQ_W +: SEQ_W];
            end
        end
    end

    sg_decide #(.SEQ_W(SEQ_W)) u_decide (
        .valid      (req_valid),
        .fault      (req_fault),
        .cls        (req_cls),
        .seq        (req_seq),
        .oldest_seq (req_oldest_seq),
        .armed      (sel_armed),
        .saved_seq  (sel_saved),
        .ns_active  (sel_ns_active),
        .ns_seq     (sel_ns_seq),
        .grant      (req_grant),
        .stall      (req_stall),
        .marked     (req_serialized),
        .arm        (dec_arm),
        .consume    (dec_consume)
    );

    // One serialization state machine per hardware thread
    for (genvar t = 0; t < NT; t++) begin : g_thread
        assign arm_vec[t]     = dec_arm     && (req_tid == TID_W'(t));
        assign consume_vec[t] = dec_consume && (req_tid == TID_W'(t));

        sg_thread_fsm #(.SEQ_W(SEQ_W)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (thread_flush[t]),
            .arm       (arm_vec[t]),
            .consume   (consume_vec[t]),
            .arm_seq   (req_seq),
            .armed     (armed_vec[t]),
            .saved_seq (saved_vec[t*SEQ_W +: SEQ_W])
        );
    end

    sg_ctrl_limiter #(.LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_req   (ex_ctrl_req),
        .ctrl_grant (ex_ctrl_grant)
    );

    p_fault_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fault) |-> (req_grant && !req_serialized));

    p_oldest_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && !req_fault && (req_ser_before || req_reg_access || req_serialized))
            |-> (req_seq == req_oldest_seq));

    p_nonspec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && !req_fault && sel_ns_active) |-> (req_seq <= sel_ns_seq));

    p_handshake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid ? (req_grant != req_stall) : (!req_grant && !req_stall && !req_serialized));

endmodule

// File: tb/serial_gate_bench.sv
`timescale 1ns/100ps
module serial_gate_bench;

    localparam int NT    = 2;
    localparam int SEQ_W = 16;
    localparam int LANES = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic [0:0]          req_tid = '0;
    logic [SEQ_W-1:0]    req_seq = '0;
    logic                req_fault = 1'b0;
    logic                req_ser_before = 1'b0;
    logic                req_ser_after = 1'b0;
    logic                req_reg_access = 1'b0;
    logic                req_store_cond = 1'b0;
    logic [SEQ_W-1:0]    req_oldest_seq = '0;
    logic [NT-1:0]       ns_active = '0;
    logic [NT*SEQ_W-1:0] ns_seq = '0;
    logic [NT-1:0]       thread_flush = '0;
    logic [LANES-1:0]    ex_ctrl_req = '0;
    logic                req_grant;
    logic                req_stall;
    logic                req_serialized;
    logic [LANES-1:0]    ex_ctrl_grant;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    // reference model state
    bit               m_armed [NT];
    logic [SEQ_W-1:0] m_saved [NT];

    always #2.5 clk = ~clk;   // 200 MHz

    serial_gate #(.NT(NT), .SEQ_W(SEQ_W), .LANES(LANES)) u_serial_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tid(req_tid),
        .req_seq(req_seq), .req_fault(req_fault), .req_ser_before(req_ser_before),
        .req_ser_after(req_ser_after), .req_reg_access(req_reg_access),
        .req_store_cond(req_store_cond), .req_oldest_seq(req_oldest_seq),
        .ns_active(ns_active), .ns_seq(ns_seq), .thread_flush(thread_flush),
        .ex_ctrl_req(ex_ctrl_req), .req_grant(req_grant), .req_stall(req_stall),
        .req_serialized(req_serialized), .ex_ctrl_grant(ex_ctrl_grant)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One request cycle: drive at falling edge, compare 1 ns later, model updates at rising edge
    task automatic step(input bit v, input int tid, input int seq, input int oldest,
                        input bit f, input bit sb, input bit sa, input bit ra, input bit sc,
                        input bit nsa, input int nss, input bit [NT-1:0] fl, input string tag);
        bit mk, st_ord, st_ns, g;
        @(negedge clk);
        req_valid = v; req_tid = tid[0]; req_seq = seq[SEQ_W-1:0];
        req_oldest_seq = oldest[SEQ_W-1:0]; req_fault = f;
        req_ser_before = sb; req_ser_after = sa; req_reg_access = ra; req_store_cond = sc;
        ns_active = '0; ns_seq = '0;
        ns_active[tid] = nsa; ns_seq[tid*SEQ_W +: SEQ_W] = nss[SEQ_W-1:0];
        thread_flush = fl;
        #1;
        mk     = m_armed[tid] && (seq[SEQ_W-1:0] > m_saved[tid]);
        st_ord = (sb || ra || mk) && (seq != oldest);
        st_ns  = nsa && (seq > nss);
        g      = v && (f || !(st_ord || st_ns));
        check(req_grant == g, {tag, " grant (R3 R5 R6)"}, req_grant, g);
        check(req_stall == (v && !g), {tag, " stall R11"}, req_stall, v && !g);
        check(req_serialized == (v && !f && mk), {tag, " serialized R2"}, req_serialized, v && !f && mk);
        @(posedge clk);
        for (int t = 0; t < NT; t++) begin
            if (fl[t]) m_armed[t] = 1'b0;
            else if (t == tid && g && !f) begin
                if (sc || sa) begin m_armed[t] = 1'b1; m_saved[t] = seq[SEQ_W-1:0]; end
                else if (mk) m_armed[t] = 1'b0;
            end
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        int seqc;
        for (int t = 0; t < NT; t++) begin m_armed[t] = 1'b0; m_saved[t] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state, plain request with a large number is not marked
        step(1, 0, 500, 1, 0,0,0,0,0, 0,0, 2'b00, "R1 reset t0");
        step(1, 1, 900, 2, 0,0,0,0,0, 0,0, 2'b00, "R1 reset t1");
        // R11: idle cycle
        step(0, 0, 5, 1, 0,1,0,0,0, 0,0, 2'b00, "R11 idle");

        // R8: arm t0, marked request stalls while not oldest, flag persists
        step(1, 0, 10, 3, 0,0,0,0,1, 0,0, 2'b00, "R4 arm sc");
        for (int i = 0; i < 3; i++)
            step(1, 0, 11, 10, 0,0,0,0,0, 0,0, 2'b00, "R8 held");
        // R10: thread 1 unaffected
        step(1, 1, 50, 40, 0,0,0,0,0, 0,0, 2'b00, "R10 other thread");
        // R2: equal number not marked
        step(1, 0, 10, 3, 0,0,0,0,0, 0,0, 2'b00, "R2 equal not marked");
        step(1, 0, 11, 11, 0,0,0,0,0, 0,0, 2'b00, "R8 granted consumes");
        step(1, 0, 12, 5, 0,0,0,0,0, 0,0, 2'b00, "R8 after consume");

        // R9: flush clears, and beats arming in the same cycle
        step(1, 0, 20, 3, 0,0,1,0,0, 0,0, 2'b00, "R4 arm after");
        step(0, 0, 0, 0, 0,0,0,0,0, 0,0, 2'b01, "R9 flush");
        step(1, 0, 21, 3, 0,0,0,0,0, 0,0, 2'b00, "R9 cleared");
        step(1, 1, 30, 3, 0,0,0,0,1, 0,0, 2'b10, "R9 flush beats arm");
        step(1, 1, 31, 3, 0,0,0,0,0, 0,0, 2'b00, "R9 not armed");

        // Near-exhaustive sweep of class flags, fault, oldest match, non-spec hazard
        seqc = 100;
        for (int pass = 0; pass < 2; pass++)
            for (int fl = 0; fl < 32; fl++)
                for (int k = 0; k < 8; k++) begin
                    int s, o, n;
                    s = (pass == 1 && k == 7) ? 2 : seqc;
                    o = k[0] ? s : s - 1;
                    n = k[2] ? s - 1 : s + 1;
                    step(1, (fl + k + pass) % NT, s, o, fl[4], fl[0], fl[1], fl[2], fl[3],
                         k[1], n, 2'b00, "sweep");
                    seqc += 3;
                end

        // R7: control-lane limiter, all patterns
        for (int r = 0; r < (1 << LANES); r++) begin
            logic [LANES-1:0] rq, eg;
            rq = r[LANES-1:0];
            eg = rq & (~rq + 1'b1);
            @(negedge clk); ex_ctrl_req = rq; #1;
            check(ex_ctrl_grant == eg, "R7 control lane", int'(ex_ctrl_grant), int'(eg));
        end
        @(negedge clk); ex_ctrl_req = '0;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule